// File: doc/BRIEF.md
# Real-Time Clock Counter and Alarm Register Block

This block is a memory-mapped real-time-clock core. It holds a day count and an hours, minutes and seconds time of day. The time advances by one second on each pulse of an external 1 Hz tick enable, but only while the control register's run bit is set. The block compares the time with a set of alarm registers. It collects the alarm match and several externally generated periodic tick pulses into a sticky status register. Status bits are cleared by writing a one to them.

Software reaches the block through a plain 32-bit register port. The port takes a byte offset on word boundaries and a write strobe. Reads are combinational. A single interrupt line is high whenever a status bit and its matching enable bit are both set. The reference-clock select field in the control register is only stored for software and read back. The tick pulses themselves come from outside the block.

Top module: `rtc_regblock`

## Requirements
- R1: After reset every register reads zero: time, day, alarm, control, status and enable. The interrupt output is low.
- R2: Registers sit at byte offsets 0x00 (hours/minutes), 0x04 (seconds), 0x08 (alarm hours/minutes), 0x0C (alarm seconds), 0x10 (control), 0x14 (status), 0x18 (enable), 0x20 (day) and 0x24 (alarm day), decoded from addr[5:2]. In both hours/minutes registers the hour is held in bits 12:8 and the minute in bits 5:0. Seconds occupy bits 5:0. Unwritable bits read zero, and any other offset reads zero.
- R3: While control bit 7 is set, a 1 Hz tick advances the time at the next clock edge. Seconds go from 59 to 0 and carry into minutes. Minutes go from 59 to 0 and carry into hours. Hours go from 23 to 0 and carry into the day. While bit 7 is clear, ticks leave the time unchanged.
- R4: The day counter is DAY_W bits wide and wraps from all ones to zero.
- R5: A write to the hours/minutes, seconds or day register in the same cycle as a tick stores the written value. In that cycle no field of the time advances.
- R6: Status bit 2 sets on the tick whose advanced day, hour, minute and second all equal the alarm registers.
- R7: A 1 Hz tick sets status bit 4, a 2 Hz tick sets bit 7, and sample tick i sets bit 8+i. These bits set whether or not the matching enable bit is set, and ticks set them even while control bit 7 is clear. A set in the same cycle as a clear wins.
- R8: Writing the status register clears each bit written as one and leaves each bit written as zero. Writing all ones clears every bit.
- R9: The interrupt output is high exactly when the bitwise AND of status and enable is non-zero.
- R10: Control keeps only bit 7 (run) and bits 6:5 (clock select). The enable register keeps only bits 2, 4, 7 and 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle 1 Hz tick pulse |
| tick_2hz | input | 1 | One-cycle 2 Hz tick pulse |
| tick_smp | input | 8 | One-cycle sampling tick pulses |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq | output | 1 | Interrupt request |

## Verification
Register reads are combinational, so a read result is due in the same cycle that addr is applied. The time counters, the alarm status bit, the tick status bits and any written register all change at the first rising edge after their tick or write. The interrupt follows status and enable with no further delay. The bench applies every stimulus just after a falling edge and updates its reference model at the rising edge that consumes it. It reads registers and the interrupt only after the next falling edge, once the design has settled.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 32;
    localparam int STAT_W   = 16;
    localparam int SMP_N    = 8;

    localparam logic [ADDR_W-1:0] OFF_HM   = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_SEC  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_AHM  = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_ASEC = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_STAT = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_IEN  = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_DAY  = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_ADAY = 6'h24;

    localparam int ST_ALARM = 2;
    localparam int ST_1HZ   = 4;
    localparam int ST_2HZ   = 7;
    localparam int ST_SMP0  = 8;
    localparam logic [STAT_W-1:0] STAT_MASK = 16'hFF94;

    localparam int CTRL_RUN  = 7;
    localparam int CTRL_SELL = 5;

    localparam logic [5:0] SEC_TOP = 6'd59;
    localparam logic [5:0] MIN_TOP = 6'd59;
    localparam logic [4:0] HR_TOP  = 5'd23;

    typedef struct packed {
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sc;
    } hms_t;
endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_hm,
    input  logic             wr_sec,
    input  logic             wr_day,
    input  logic [4:0]       wd_hr,
    input  logic [5:0]       wd_mn,
    input  logic [5:0]       wd_sc,
    input  logic [DAY_W-1:0] wd_day,
    output hms_t             hms_q,
    output logic [DAY_W-1:0] day_q,
    output hms_t             hms_inc,
    output logic [DAY_W-1:0] day_inc,
    output logic             adv
);
    typedef struct packed {
        hms_t             hms;
        logic [DAY_W-1:0] day;
    } tstate_t;

    tstate_t st_d, st_q;
    logic    c_mn, c_hr, c_day, any_wr;

    always_comb begin
        c_mn       = st_q.hms.sc >= SEC_TOP;
        c_hr       = c_mn && (st_q.hms.mn >= MIN_TOP);
        c_day      = c_hr && (st_q.hms.hr >= HR_TOP);
        hms_inc.sc = c_mn ? 6'd0 : st_q.hms.sc + 6'd1;
        hms_inc.mn = c_hr ? 6'd0 : (c_mn ? st_q.hms.mn + 6'd1 : st_q.hms.mn);
        hms_inc.hr = c_day ? 5'd0 : (c_hr ? st_q.hms.hr + 5'd1 : st_q.hms.hr);
        day_inc    = st_q.day + DAY_W'(c_day);
        any_wr     = wr_hm | wr_sec | wr_day;
        adv        = run & ~any_wr;

        st_d = st_q;
        if (adv) begin
            st_d.hms = hms_inc;
            st_d.day = day_inc;
        end
        if (wr_hm) begin
            st_d.hms.hr = wd_hr;
            st_d.hms.mn = wd_mn;
        end
        if (wr_sec) st_d.hms.sc = wd_sc;
        if (wr_day) st_d.day    = wd_day;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hms_q = st_q.hms;
    assign day_q = st_q.day;

    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !any_wr && st_q.hms.sc == SEC_TOP) |=> (st_q.hms.sc == 6'd0));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !any_wr) |=> $stable(st_q));

    assert_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sec |=> (st_q.hms.sc == $past(wd_sc)));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] ev,
    input  logic              clr_wr,
    input  logic              en_wr,
    input  logic [STAT_W-1:0] wd,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] en_q,
    output logic              irq
);
    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] en;
    } istate_t;

    istate_t is_d, is_q;
    logic [STAT_W-1:0] clr_mask;

    always_comb begin
        clr_mask    = clr_wr ? wd : '0;
        is_d.stat   = ((is_q.stat & ~clr_mask) | ev) & STAT_MASK;
        is_d.en     = en_wr ? (wd & STAT_MASK) : is_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) is_q <= '0;
        else        is_q <= is_d;
    end

    assign stat_q = is_q.stat;
    assign en_q   = is_q.en;
    assign irq    = |(is_q.stat & is_q.en);

    assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && wd == '1 && ev == '0) |=> (stat_q == '0));

    assert_tick_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev[ST_1HZ] |=> stat_q[ST_1HZ]);
endmodule

// File: rtl/rtc_regblock.sv
module rtc_regblock
    import rtc_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              tick_2hz,
    input  logic [SMP_N-1:0]  tick_smp,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    typedef struct packed {
        logic             run;
        logic [1:0]       csel;
        hms_t             a_hms;
        logic [DAY_W-1:0] a_day;
    } rstate_t;

    rstate_t rs_d, rs_q;

    hms_t              hms_q, hms_inc;
    logic [DAY_W-1:0]  day_q, day_inc;
    logic              adv, alarm_ev;
    logic [STAT_W-1:0] ev, stat_q, en_q;
    logic [3:0]        widx;
    logic              w_hm, w_sec, w_ahm, w_asec, w_ctrl, w_stat, w_ien, w_day, w_aday;
    logic              unused_bits;

    assign unused_bits = ^{addr[1:0], wdata[31:16]};
    assign widx        = addr[5:2];

    always_comb begin
        w_hm   = wr_en && widx == OFF_HM[5:2];
        w_sec  = wr_en && widx == OFF_SEC[5:2];
        w_ahm  = wr_en && widx == OFF_AHM[5:2];
        w_asec = wr_en && widx == OFF_ASEC[5:2];
        w_ctrl = wr_en && widx == OFF_CTRL[5:2];
        w_stat = wr_en && widx == OFF_STAT[5:2];
        w_ien  = wr_en && widx == OFF_IEN[5:2];
        w_day  = wr_en && widx == OFF_DAY[5:2];
        w_aday = wr_en && widx == OFF_ADAY[5:2];
    end

    rtc_time_core #(.DAY_W(DAY_W)) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (rs_q.run & tick_1hz),
        .wr_hm   (w_hm),
        .wr_sec  (w_sec),
        .wr_day  (w_day),
        .wd_hr   (wdata[12:8]),
        .wd_mn   (wdata[5:0]),
        .wd_sc   (wdata[5:0]),
        .wd_day  (wdata[DAY_W-1:0]),
        .hms_q   (hms_q),
        .day_q   (day_q),
        .hms_inc (hms_inc),
        .day_inc (day_inc),
        .adv     (adv)
    );

    always_comb begin
        alarm_ev             = adv && (hms_inc == rs_q.a_hms) && (day_inc == rs_q.a_day);
        ev                   = '0;
        ev[ST_ALARM]         = alarm_ev;
        ev[ST_1HZ]           = tick_1hz;
        ev[ST_2HZ]           = tick_2hz;
        ev[ST_SMP0 +: SMP_N] = tick_smp;
    end

    rtc_irq_ctrl u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .clr_wr (w_stat),
        .en_wr  (w_ien),
        .wd     (wdata[STAT_W-1:0]),
        .stat_q (stat_q),
        .en_q   (en_q),
        .irq    (irq)
    );

    always_comb begin
        rs_d = rs_q;
        if (w_ctrl) begin
            rs_d.run  = wdata[CTRL_RUN];
            rs_d.csel = wdata[CTRL_SELL +: 2];
        end
        if (w_ahm) begin
            rs_d.a_hms.hr = wdata[12:8];
            rs_d.a_hms.mn = wdata[5:0];
        end
        if (w_asec) rs_d.a_hms.sc = wdata[5:0];
        if (w_aday) rs_d.a_day    = wdata[DAY_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    always_comb begin
        rdata = '0;
        case ({widx, 2'b00})
            OFF_HM:   rdata = {19'd0, hms_q.hr, 2'd0, hms_q.mn};
            OFF_SEC:  rdata = {26'd0, hms_q.sc};
            OFF_AHM:  rdata = {19'd0, rs_q.a_hms.hr, 2'd0, rs_q.a_hms.mn};
            OFF_ASEC: rdata = {26'd0, rs_q.a_hms.sc};
            OFF_CTRL: rdata = {24'd0, rs_q.run, rs_q.csel, 5'd0};
            OFF_STAT: rdata = {16'd0, stat_q};
            OFF_IEN:  rdata = {16'd0, en_q};
            OFF_DAY:  rdata = DATA_W'(day_q);
            OFF_ADAY: rdata = DATA_W'(rs_q.a_day);
            default:  rdata = '0;
        endcase
    end

    assert_alarm_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[ST_ALARM]) |-> $past(tick_1hz && rs_q.run));

    assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
endmodule

// File: tb/tb_rtc_regblock.sv
module tb_rtc_regblock;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 9;
    localparam int DAYS       = 1 << DW;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        tick_1hz = 0, tick_2hz = 0;
    logic [7:0]  tick_smp = '0;
    logic        wr_en = 0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0, errors = 0;
    bit done = 0;

    int m_sc, m_mn, m_hr, m_day, a_sc, a_mn, a_hr, a_day, m_run, m_csel;
    logic [15:0] m_stat, m_en;

    rtc_regblock #(.DAY_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_2hz(tick_2hz),
        .tick_smp(tick_smp), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_reg(input logic [5:0] a);
        case (a)
            6'h00: return 32'((m_hr << 8) | m_mn);
            6'h04: return 32'(m_sc);
            6'h08: return 32'((a_hr << 8) | a_mn);
            6'h0C: return 32'(a_sc);
            6'h10: return 32'((m_run << 7) | (m_csel << 5));
            6'h14: return {16'd0, m_stat};
            6'h18: return {16'd0, m_en};
            6'h20: return 32'(m_day);
            6'h24: return 32'(a_day);
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_edge(input bit w, input logic [5:0] a, input logic [31:0] d,
                              input bit t1, input bit t2, input logic [7:0] s);
        bit twr, adv, alm;
        int nsc, nmn, nhr, nday;
        logic [15:0] ev, clr;
        twr = w && (a == 6'h00 || a == 6'h04 || a == 6'h20);
        adv = (m_run != 0) && t1 && !twr;
        nsc = m_sc; nmn = m_mn; nhr = m_hr; nday = m_day;
        if (adv) begin
            if (nsc >= 59) begin
                nsc = 0;
                if (nmn >= 59) begin
                    nmn = 0;
                    if (nhr >= 23) begin nhr = 0; nday = (nday + 1) % DAYS; end
                    else nhr++;
                end else nmn++;
            end else nsc++;
        end
        alm = adv && nsc == a_sc && nmn == a_mn && nhr == a_hr && nday == a_day;
        ev = '0; ev[2] = alm; ev[4] = t1; ev[7] = t2; ev[15:8] = s;
        clr = (w && a == 6'h14) ? d[15:0] : 16'd0;
        m_stat = ((m_stat & ~clr) | ev) & 16'hFF94;
        m_sc = nsc; m_mn = nmn; m_hr = nhr; m_day = nday;
        if (w) case (a)
            6'h00: begin m_hr = int'(d[12:8]); m_mn = int'(d[5:0]); end
            6'h04: m_sc = int'(d[5:0]);
            6'h08: begin a_hr = int'(d[12:8]); a_mn = int'(d[5:0]); end
            6'h0C: a_sc = int'(d[5:0]);
            6'h10: begin m_run = int'(d[7]); m_csel = int'(d[6:5]); end
            6'h18: m_en = d[15:0] & 16'hFF94;
            6'h20: m_day = int'(d[DW-1:0]);
            6'h24: a_day = int'(d[DW-1:0]);
            default: ;
        endcase
    endtask

    task automatic step(input bit w, input logic [5:0] a, input logic [31:0] d,
                        input bit t1, input bit t2, input logic [7:0] s);
        wr_en = w; addr = a; wdata = d; tick_1hz = t1; tick_2hz = t2; tick_smp = s;
        @(posedge clk);
        model_edge(w, a, d, t1, t2, s);
        @(negedge clk);
        wr_en = 0; tick_1hz = 0; tick_2hz = 0; tick_smp = '0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        step(1, a, d, 0, 0, '0);
    endtask

    task automatic tick();
        step(0, 6'h00, 0, 1, 0, '0);
    endtask

    task automatic rd(input string req, input logic [5:0] a, input logic [31:0] exp);
        addr = a; #1;
        chk(req, rdata, exp);
    endtask

    task automatic rd_all(input string req);
        logic [5:0] offs [9] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h20, 6'h24};
        foreach (offs[k]) rd(req, offs[k], exp_reg(offs[k]));
        chk(req, 32'(irq), 32'(|(m_stat & m_en)));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_sc = 0; m_mn = 0; m_hr = 0; m_day = 0; a_sc = 0; a_mn = 0; a_hr = 0; a_day = 0;
        m_run = 0; m_csel = 0; m_stat = '0; m_en = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        rd_all("R1");

        // R3: no counting while run bit clear; R7: tick status still sets
        tick();
        rd("R3", 6'h04, 32'd0);
        rd("R7", 6'h14, 32'h0010);

        // R10: control readback
        wr(6'h10, 32'hFFFF_FFFF);
        rd("R10", 6'h10, 32'h0000_00E0);
        wr(6'h10, 32'h0000_0080);
        rd("R10", 6'h10, 32'h0000_0080);

        // R3: full carry chain
        wr(6'h00, 32'h0000_173B); wr(6'h04, 32'd59); wr(6'h20, 32'd5);
        tick();
        rd("R3", 6'h00, 32'd0); rd("R3", 6'h04, 32'd0); rd("R3", 6'h20, 32'd6);
        wr(6'h00, 32'h0000_0A3B); wr(6'h04, 32'd59);
        tick();
        rd("R3", 6'h00, 32'h0000_0B00);

        // R4: day wrap at DAY_W
        wr(6'h00, 32'h0000_173B); wr(6'h04, 32'd59); wr(6'h20, 32'd511);
        tick();
        rd("R4", 6'h20, 32'd0);

        // R5: write wins over tick
        step(1, 6'h04, 32'd10, 1, 0, '0);
        rd("R5", 6'h04, 32'd10);
        rd("R5", 6'h00, 32'd0);

        // R6: alarm at day 0 00:00:12
        wr(6'h08, 32'd0); wr(6'h0C, 32'd12); wr(6'h24, 32'd0);
        wr(6'h14, 32'hFFFF_FFFF);
        rd("R8", 6'h14, 32'd0);
        tick();
        rd("R6", 6'h14, 32'h0010);
        tick();
        rd("R6", 6'h14, 32'h0014);

        // R9: interrupt masking
        chk("R9", 32'(irq), 32'd0);
        wr(6'h18, 32'h0000_0004);
        chk("R9", 32'(irq), 32'd1);
        wr(6'h18, 32'h0000_0000);
        chk("R9", 32'(irq), 32'd0);

        // R8: write-one-to-clear
        wr(6'h14, 32'h0000_0004);
        rd("R8", 6'h14, 32'h0010);
        wr(6'h14, 32'h0000_0000);
        rd("R8", 6'h14, 32'h0010);

        // R7: tick bits, set wins over clear
        step(0, 6'h00, 0, 0, 1, 8'h81);
        rd("R7", 6'h14, 32'h8190);
        step(1, 6'h14, 32'hFFFF_FFFF, 0, 1, '0);
        rd("R7", 6'h14, 32'h0080);

        // R10: enable writable mask
        wr(6'h18, 32'hFFFF_FFFF);
        rd("R10", 6'h18, 32'h0000_FF94);
        chk("R9", 32'(irq), 32'd1);

        // R2: packing and unmapped offset
        wr(6'h00, 32'hFFFF_1734);
        rd("R2", 6'h00, 32'h0000_1734);
        rd("R2", 6'h1C, 32'd0);
        rd("R2", 6'h3C, 32'd0);
        rd_all("R2");

        // random phase, checked against the model
        for (int i = 0; i < 3000; i++) begin
            bit w;
            logic [5:0] a;
            logic [31:0] d;
            int pick;
            w = ($urandom_range(0, 7) == 0);
            pick = $urandom_range(0, 8);
            a = (pick < 8) ? 6'(pick * 4) : 6'h24;
            d = $urandom;
            if (a == 6'h00 || a == 6'h08)
                d = {19'd0, 5'($urandom_range(0, 23)), 2'd0, 6'($urandom_range(0, 59))};
            else if (a == 6'h04 || a == 6'h0C)
                d = 32'($urandom_range(0, 59));
            else if (a == 6'h10)
                d = ($urandom_range(0, 3) != 0) ? (d | 32'h80) : d;
            else if (a == 6'h1C)
                d = 32'($urandom_range(0, 511));
            if (i % 400 == 7) begin
                // aim the alarm two seconds ahead
                int t;
                t = (m_sc + 2) % 60;
                w = 1; a = 6'h0C; d = 32'(t);
                a_hr = a_hr; 
                step(1, 6'h08, 32'((m_hr << 8) | (m_mn + (m_sc >= 58 ? 1 : 0)) % 60), 0, 0, '0);
                step(1, 6'h24, 32'(m_day), 0, 0, '0);
            end
            step(w, a, d, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
                 8'($urandom & $urandom & $urandom));
            if (i % 25 == 24) rd_all("R3");
        end
        rd_all("R6");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule